// File: doc/BRIEF.md
# Selectable-Window Moving Average

This block smooths a stream of signed 16-bit samples with a boxcar (equal-weight) average. The averaging length is chosen at run time from a small set of lengths, and most of them are not powers of two. Samples arrive on a one-cycle valid strobe at a slow, regular rate. For each sample the block produces one filtered value on an output valid/data pair, and that value then goes on to a scaling and code-conversion stage.

The block keeps a circular store of the most recent samples and a running sum. On each new sample the sum gains the newest value and loses the value that falls out of the window. The sum is divided by the number of samples held, using a multiply by a precomputed fixed-point reciprocal, and the result is rounded to the nearest integer. When the window select changes, the history is discarded and the window fills again from empty. Until the window is full, the output is the mean of the samples received so far.

Top module: `boxcar_avg`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` goes to 0 and `out_data` to 0, the sample history is emptied and the stored window select becomes 0.
- R2: `out_valid` is high for exactly the one cycle after each rising edge at which `in_valid` is high, and low otherwise.
- R3: `win_sel` picks the window length: 0 gives 1 sample, 1 gives 5, 2 gives 8, 3 gives 12, 4 gives 20, 5 gives 36, and the unused codes 6 and 7 also give 1 sample.
- R4: With a length of 1, each output equals the accepted input sample unchanged.
- R5: Once the window is full, each output is the mean of the last N accepted samples, where N is the selected length.
- R6: While fewer than N samples have been accepted since the last clear, the output is the mean of all samples accepted since that clear.
- R7: The mean is rounded to the nearest integer, with exact halves rounded away from zero, so the output is never more than half an LSB from the true mean.
- R8: At any rising edge where `win_sel` differs from the select seen at the previous edge, the history is cleared. A sample accepted at that same edge becomes the first sample of the new window.
- R9: `out_data` holds its value at every edge where `in_valid` is low, including edges where the window is changed.
- R10: Full-scale inputs (-32768 and 32767) over the longest window give exactly -32768 and 32767 with no overflow of the sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe marking a new sample |
| in_data | input | 16 | Signed two's complement sample |
| win_sel | input | 3 | Window length select |
| out_valid | output | 1 | One-cycle strobe marking a new filtered value |
| out_data | output | 16 | Signed filtered value, held between strobes |

## Verification
A sample strobed at a rising edge gives its filtered value and `out_valid` after that same edge, so both are due one cycle after the strobe. A window change is also acted on at the edge where the new select is first seen. The bench sets inputs on the falling edge and advances a behavioural queue model at the rising edge. It then compares `out_valid` and `out_data` with the model at the next falling edge, every cycle, so an early, late or missing result shows up as a mismatch. Idle cycles placed between strobes check that the output data holds and that the valid strobe stays a single cycle.

// File: rtl/boxcar_pkg.sv
// boxcar_pkg: widths, window-length decode and reciprocal constants shared
// by the moving-average block and its checker.
// Assumes: sample count never exceeds MAX_LEN; divisor = 2*count.
package boxcar_pkg;

    localparam int SMP_W   = 16;
    localparam int MAX_LEN = 36;
    localparam int SEL_W   = 3;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam int SUM_W   = SMP_W + $clog2(MAX_LEN) + 1;
    localparam int NUM_W   = SUM_W + 1;
    localparam int DEN_W   = CNT_W + 1;
    localparam int SHIFT   = NUM_W + DEN_W;
    localparam int RCP_W   = SHIFT;

    // Map the select code to a window length; unused codes mean length 1.
    function automatic logic [CNT_W-1:0] window_len(input logic [SEL_W-1:0] sel);
        case (int'(sel))
            1:       return CNT_W'(5);
            2:       return CNT_W'(8);
            3:       return CNT_W'(12);
            4:       return CNT_W'(20);
            5:       return CNT_W'(36);
            default: return CNT_W'(1);
        endcase
    endfunction

    // ceil(2^SHIFT / d); exact floor division for numerators below 2^SHIFT/d.
    function automatic logic [RCP_W-1:0] recip_ceil(input int d);
        longint unsigned one;
        longint unsigned dd;
        one = 64'd1 << SHIFT;
        if (d <= 1) return '0;
        dd = longint'(d);
        return RCP_W'((one + dd - 64'd1) / dd);
    endfunction

endpackage

// File: rtl/boxcar_ring.sv
// boxcar_ring: circular sample store. Writes the newest sample over the
// oldest and presents the sample that would leave the window.
// Assumes: len is 1..DEPTH and only changes together with clr.
module boxcar_ring #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 36,
    parameter int LEN_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     push,
    input  logic [LEN_W-1:0]         len,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] oldest
);
    localparam int PTR_W = $clog2(DEPTH);

    logic signed [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] base_ptr;
    logic [PTR_W-1:0] last_ptr;

    assign base_ptr = clr ? '0 : wptr;
    assign last_ptr = PTR_W'(len) - PTR_W'(1);
    assign oldest   = store[wptr];

    // Sample storage: write the newest sample at the current slot.
    always_ff @(posedge clk) begin
        if (push) store[base_ptr] <= din;
    end

    // Write pointer: advance and wrap at the window length, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wptr <= '0;
        else if (push)
            wptr <= (base_ptr == last_ptr) ? '0 : base_ptr + PTR_W'(1);
        else if (clr)
            wptr <= '0;
    end

endmodule

// File: rtl/boxcar_accum.sv
// boxcar_accum: running sum and fill count of the window.
// Adds each new sample, removes the leaving one once full.
// Assumes: oldest is the sample written len pushes ago when count == len.
module boxcar_accum
    import boxcar_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    push,
    input  logic [CNT_W-1:0]        len,
    input  logic signed [SMP_W-1:0] din,
    input  logic signed [SMP_W-1:0] oldest,
    output logic signed [SUM_W-1:0] sum_nxt,
    output logic [CNT_W-1:0]        cnt_nxt,
    output logic [CNT_W-1:0]        cnt_q
);
    logic signed [SUM_W-1:0] sum_q;
    logic signed [SUM_W-1:0] base_sum;
    logic [CNT_W-1:0]        base_cnt;
    logic                    full;

    // Next sum and count as if a sample were accepted this cycle.
    always_comb begin
        base_sum = clr ? '0 : sum_q;
        base_cnt = clr ? '0 : cnt_q;
        full     = (base_cnt == len);
        sum_nxt  = base_sum + SUM_W'(din) - (full ? SUM_W'(oldest) : '0);
        cnt_nxt  = full ? base_cnt : base_cnt + CNT_W'(1);
    end

    // Sum and count registers: update on a sample, zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (push) begin
            sum_q <= sum_nxt;
            cnt_q <= cnt_nxt;
        end else if (clr) begin
            sum_q <= '0;
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/boxcar_div.sv
// boxcar_div: rounded signed division of the sum by the sample count via a
// reciprocal multiply. q = sign * floor((2|sum| + cnt) / (2 cnt)).
// Assumes: cnt is 1..MAX_LEN and the mean fits in SMP_W bits.
module boxcar_div
    import boxcar_pkg::*;
(
    input  logic signed [SUM_W-1:0] sum,
    input  logic [CNT_W-1:0]        cnt,
    output logic signed [SMP_W-1:0] quo
);
    localparam int PROD_W = NUM_W + RCP_W;

    logic [RCP_W-1:0]  rtab [MAX_LEN + 1];
    logic              neg;
    logic [SUM_W-1:0]  mag;
    logic [NUM_W-1:0]  num;
    logic [PROD_W-1:0] prod;
    logic [NUM_W-1:0]  qmag;

    // One reciprocal constant per possible count (divisor 2*count).
    for (genvar g = 0; g <= MAX_LEN; g++) begin : g_rcp
        assign rtab[g] = recip_ceil(2 * g);
    end

    // Magnitude, rounding offset, multiply and sign restore.
    always_comb begin
        neg  = sum[SUM_W-1];
        mag  = neg ? SUM_W'(-sum) : SUM_W'(sum);
        num  = {mag, 1'b0} + NUM_W'(cnt);
        prod = PROD_W'(num) * PROD_W'(rtab[cnt]);
        qmag = NUM_W'(prod >> SHIFT);
        quo  = neg ? -SMP_W'(qmag) : SMP_W'(qmag);
    end

endmodule

// File: rtl/boxcar_avg.sv
// boxcar_avg: run-time selectable boxcar average of signed samples.
// Detects window changes, clears history, and registers one rounded mean
// per accepted sample.
// Assumes: in_valid is a single-cycle strobe; win_sel may change any cycle.
module boxcar_avg
    import boxcar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SMP_W-1:0]  in_data,
    input  logic [SEL_W-1:0]  win_sel,
    output logic              out_valid,
    output logic [SMP_W-1:0]  out_data
);
    logic [SEL_W-1:0]        win_q;
    logic                    sel_chg;
    logic [CNT_W-1:0]        len;
    logic signed [SMP_W-1:0] oldest;
    logic signed [SUM_W-1:0] sum_nxt;
    logic [CNT_W-1:0]        cnt_nxt;
    logic [CNT_W-1:0]        cnt_q;
    logic signed [SMP_W-1:0] quo;

    assign sel_chg = (win_sel != win_q);
    assign len     = window_len(win_sel);

    boxcar_ring #(
        .DATA_W(SMP_W),
        .DEPTH (MAX_LEN),
        .LEN_W (CNT_W)
    ) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sel_chg),
        .push  (in_valid),
        .len   (len),
        .din   ($signed(in_data)),
        .oldest(oldest)
    );

    boxcar_accum u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (sel_chg),
        .push   (in_valid),
        .len    (len),
        .din    ($signed(in_data)),
        .oldest (oldest),
        .sum_nxt(sum_nxt),
        .cnt_nxt(cnt_nxt),
        .cnt_q  (cnt_q)
    );

    boxcar_div u_div (
        .sum(sum_nxt),
        .cnt(cnt_nxt),
        .quo(quo)
    );

    // Remember the select seen at the last edge to spot changes.
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_sel;
    end

    // Output register: one strobe per sample, data held between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= quo;
        end
    end

endmodule

// File: rtl/boxcar_avg_chk.sv
// boxcar_avg_chk: timing and state properties of boxcar_avg, bound in below.
// Assumes: connected to the top-level ports and the select/count registers.
module boxcar_avg_chk
    import boxcar_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [SMP_W-1:0] in_data,
    input logic [SEL_W-1:0] win_sel,
    input logic             out_valid,
    input logic [SMP_W-1:0] out_data,
    input logic [SEL_W-1:0] win_q,
    input logic [CNT_W-1:0] cnt_q
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0 && cnt_q == '0));

    p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid) |=> out_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_valid) |=> !out_valid);

    p_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid && window_len(win_sel) == CNT_W'(1))
            |=> out_data == $past(in_data));

    p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= window_len(win_q));

    p_change_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_valid && win_sel != win_q) |=> cnt_q == '0);

    p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_valid) |=> $stable(out_data));

endmodule

bind boxcar_avg boxcar_avg_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .win_sel  (win_sel),
    .out_valid(out_valid),
    .out_data (out_data),
    .win_q    (win_q),
    .cnt_q    (cnt_q)
);

// File: tb/tb_boxcar_avg.sv
// tb_boxcar_avg: queue-based reference model compared on every clock.
module tb_boxcar_avg;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_data;
    logic [2:0]  win_sel;
    logic        out_valid;
    logic [15:0] out_data;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    int   mq[$];
    int   m_sel   = 0;
    int   exp_v   = 0;
    int   exp_d   = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    boxcar_avg dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .win_sel  (win_sel),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    function automatic int win_of(input int s);
        case (s)
            1: return 5;
            2: return 8;
            3: return 12;
            4: return 20;
            5: return 36;
            default: return 1;
        endcase
    endfunction

    function automatic int ref_mean();
        longint s = 0;
        longint n, mag, qq;
        bit neg;
        foreach (mq[i]) s += mq[i];
        n   = mq.size();
        neg = (s < 0);
        mag = neg ? -s : s;
        qq  = (2 * mag + n) / (2 * n);
        return int'(neg ? -qq : qq);
    endfunction

    function automatic int next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'($signed(lcg[23:8]));
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: drive at falling edge, model at rising edge, compare after it.
    task automatic step(input bit v, input int d, input int s, input string tag);
        in_valid = v;
        in_data  = d[15:0];
        win_sel  = s[2:0];
        @(posedge clk);
        if (s != m_sel) begin
            mq.delete();
            m_sel = s;
        end
        if (v) begin
            mq.push_back(d);
            if (mq.size() > win_of(s)) void'(mq.pop_front());
            exp_d = ref_mean();
        end
        exp_v = v ? 1 : 0;
        @(negedge clk);
        chk(tag, "out_valid", int'(out_valid), exp_v);
        chk(tag, "out_data", int'($signed(out_data)), exp_d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        win_sel  = '0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "out_data", int'($signed(out_data)), 0);
        rst_n = 1'b1;
        step(1'b0, 0, 0, "R1");

        // R4: length 1 passes samples through, including extremes
        step(1'b1, 100, 0, "R4");
        step(1'b1, -5, 0, "R4");
        step(1'b0, 0, 0, "R9");
        step(1'b1, 32767, 0, "R4");
        step(1'b1, -32768, 0, "R4");

        // R8/R6: change to 5 with a sample in the same cycle, then fill
        step(1'b1, 10, 1, "R8");
        step(1'b1, 20, 1, "R6");
        step(1'b0, 0, 1, "R9");
        step(1'b1, 30, 1, "R6");
        step(1'b1, 40, 1, "R6");
        step(1'b0, 0, 1, "R2");
        step(1'b1, 50, 1, "R6");
        step(1'b1, 60, 1, "R5");
        step(1'b1, 70, 1, "R5");
        step(1'b0, 0, 1, "R9");

        // R8/R9: change to 8 without a sample; data holds, then restart
        step(1'b0, 0, 2, "R9");
        step(1'b0, 0, 2, "R9");
        step(1'b1, 1, 2, "R8");
        step(1'b1, 2, 2, "R7");

        // R7: negative half rounds away from zero (window 12)
        step(1'b1, -1, 3, "R8");
        step(1'b1, -2, 3, "R7");
        step(1'b1, 3, 3, "R7");

        // R5: pseudo-random data over windows 12, 20, 36 with gaps
        for (int s = 3; s <= 5; s++) begin
            for (int i = 0; i < 90; i++) begin
                step(1'b1, next_rand(), s, "R5");
                if (i % 3 == 0) step(1'b0, 0, s, "R9");
            end
        end

        // R3: every code including unused ones
        for (int s = 0; s <= 7; s++) begin
            for (int i = 0; i < 40; i++) step(1'b1, next_rand(), s, "R3");
        end

        // R10: full-scale inputs over the longest window
        for (int i = 0; i < 40; i++) step(1'b1, -32768, 5, "R10");
        for (int i = 0; i < 40; i++) step(1'b1, 32767, 5, "R10");
        step(1'b0, 0, 5, "R10");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule